// File: doc/BRIEF.md
# Boot ROM Window Controller

This block decides whether a 1 KB boot ROM answers a read on the host memory bus. It compares each qualified memory read against a fixed window in the 16-bit address space. When the address falls inside the window and the ROM is currently mapped, the block asserts a registered chip-select and drives the addressed ROM byte. Outside such a cycle it drives zero.

Four board switches configure the block, and each passes through a two-flop synchronizer before use. The first switch holds the ROM permanently off. The second switch arms a one-shot shadow-off: an I/O write to port 0x40 sets a sticky latch that unmaps the ROM until the next reset. The third switch is passed to firmware as a boot-mode bit, which selects a direct bootstrap instead of the monitor. The fourth switch blocks the format permission that goes to the disk controller.

The ROM contents come from a computed table that initializes a RAM-style array, so an FPGA flow can infer block RAM for it.

Top module: `boot_rom_window`

## Requirements
- R1: A memory read asserts `rom_cs` one cycle later only if `addr[15:10]` equals 6'b110000, which covers 0xC000 through 0xC3FF. Any other address, including aliases of the low ten bits, leaves `rom_cs` low.
- R2: While the synchronized ROM-off switch is high, no address asserts `rom_cs`.
- R3: With the synchronized auto-off switch high, an `io_wr` to port 0x40 unmaps the ROM from the next read onward. The ROM stays unmapped even if the auto-off switch is later turned off. A write to any other port has no effect.
- R4: With the auto-off switch low, a write to port 0x40 leaves the ROM mapped.
- R5: Reset clears the shadow-off latch, so the ROM is mapped again after every reset.
- R6: `boot_direct` presents the synchronized boot-direct switch to firmware.
- R7: `fmt_permit` follows `fmt_req` with one cycle of delay. It is forced low while the synchronized format-lock switch is high.
- R8: `rom_data` carries the ROM byte only in the cycle where `rom_cs` is high, and is zero at all other times. The byte at window offset i is i[7:0] XOR {i[9:8], 6'b000000}. A cycle without `mem_rd` never asserts `rom_cs`.
- R9: A switch change reaches the outputs on the third rising edge after it occurs: two synchronizer stages followed by one output register.
- R10: During reset, `rom_cs`, `rom_data`, `boot_direct` and `fmt_permit` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_rom_off | input | 1 | Switch: ROM always off (asynchronous) |
| sw_auto_off | input | 1 | Switch: arm the shadow-off by I/O write (asynchronous) |
| sw_boot_direct | input | 1 | Switch: direct bootstrap (asynchronous) |
| sw_fmt_lock | input | 1 | Switch: block disk formatting (asynchronous) |
| mem_rd | input | 1 | Qualified memory read cycle |
| addr | input | 16 | Memory address |
| io_wr | input | 1 | Qualified I/O write cycle |
| io_port | input | 8 | I/O port number |
| fmt_req | input | 1 | Format request from the disk side |
| rom_cs | output | 1 | Registered ROM chip-select |
| rom_data | output | 8 | ROM byte, zero when not selected |
| boot_direct | output | 1 | Boot-mode bit for firmware |
| fmt_permit | output | 1 | Format permission to the disk controller |

## Verification
A shadow-off latch that sets wrongly shows up as a missing `rom_cs` on the first window read after the stray write. A latch that fails to set, or fails to stay set, shows up as a `rom_cs` on the first read after the port 0x40 write, or after the auto-off switch is released. A decode error shows up as `rom_cs` one cycle after a read at a boundary or alias address, and a wrong table entry shows up in `rom_data` in that same cycle. A fault in synchronizer depth moves a switch effect from the third edge to a different edge, and the bench probes for this at edges two and three.

// File: rtl/boot_rom_pkg.sv
package boot_rom_pkg;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned ROM_AW      = 10;
  localparam int unsigned PORT_W      = 8;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned NUM_SW      = 4;

  // switch vector bit positions
  localparam int unsigned SW_OFF  = 0;
  localparam int unsigned SW_AUTO = 1;
  localparam int unsigned SW_BOOT = 2;
  localparam int unsigned SW_LOCK = 3;
endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_async;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/rom_table.sv
module rom_table #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // byte i = low byte of i, XOR the bits above it placed at the top
  function automatic logic [DW-1:0] entry(input int unsigned i);
    logic [DW-1:0] lo;
    logic [DW-1:0] hi;
    lo = DW'(i);
    hi = DW'(i >> DW) << (DW - (AW - DW));
    return lo ^ hi;
  endfunction

  initial begin
    for (int unsigned i = 0; i < DEPTH; i++) begin
      mem[i] = entry(i);
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/boot_rom_window.sv
module boot_rom_window
  import boot_rom_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC000,
  parameter logic [PORT_W-1:0] OFF_PORT = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rom_off,
  input  logic              sw_auto_off,
  input  logic              sw_boot_direct,
  input  logic              sw_fmt_lock,
  input  logic              mem_rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic              fmt_req,
  output logic              rom_cs,
  output logic [DATA_W-1:0] rom_data,
  output logic              boot_direct,
  output logic              fmt_permit
);
  localparam int unsigned TAG_W = ADDR_W - ROM_AW;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:ROM_AW];

  logic [NUM_SW-1:0] sw_raw;
  logic [NUM_SW-1:0] sw_s;
  logic rom_off_s, auto_off_s, boot_dir_s, fmt_lock_s;
  logic off_latch;
  logic win_hit, mapped, off_cmd;
  logic cs_q;
  logic [DATA_W-1:0] rom_q;

  assign sw_raw[SW_OFF]  = sw_rom_off;
  assign sw_raw[SW_AUTO] = sw_auto_off;
  assign sw_raw[SW_BOOT] = sw_boot_direct;
  assign sw_raw[SW_LOCK] = sw_fmt_lock;

  sw_sync #(.WIDTH(NUM_SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (sw_raw),
    .q_sync  (sw_s)
  );

  assign rom_off_s  = sw_s[SW_OFF];
  assign auto_off_s = sw_s[SW_AUTO];
  assign boot_dir_s = sw_s[SW_BOOT];
  assign fmt_lock_s = sw_s[SW_LOCK];

  assign win_hit = (addr[ADDR_W-1:ROM_AW] == WIN_TAG);
  assign mapped  = !rom_off_s && !off_latch;
  assign off_cmd = io_wr && (io_port == OFF_PORT) && auto_off_s;

  rom_table #(.AW(ROM_AW), .DW(DATA_W)) u_rom (
    .clk     (clk),
    .rd_addr (addr[ROM_AW-1:0]),
    .rd_data (rom_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      off_latch   <= 1'b0;
      cs_q        <= 1'b0;
      boot_direct <= 1'b0;
      fmt_permit  <= 1'b0;
    end else begin
      if (off_cmd) begin
        off_latch <= 1'b1;
      end
      cs_q        <= mem_rd && win_hit && mapped;
      boot_direct <= boot_dir_s;
      fmt_permit  <= fmt_req && !fmt_lock_s;
    end
  end

  assign rom_cs   = cs_q;
  assign rom_data = cs_q ? rom_q : '0;
endmodule

// File: rtl/boot_rom_window_chk.sv
module boot_rom_window_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned PW = 8,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rom_off_s,
  input logic          auto_off_s,
  input logic          fmt_lock_s,
  input logic          off_latch,
  input logic          mem_rd,
  input logic [AW-1:0] addr,
  input logic          io_wr,
  input logic [PW-1:0] io_port,
  input logic          fmt_req,
  input logic          rom_cs,
  input logic [DW-1:0] rom_data,
  input logic          fmt_permit
);
  a_r1_cs_in_window: assert property (@(posedge clk) disable iff (rst)
    rom_cs |-> ($past(addr[AW-1:AW-6]) == 6'b110000));

  a_r8_cs_needs_read: assert property (@(posedge clk) disable iff (rst)
    rom_cs |-> $past(mem_rd));

  a_r2_off_blocks_cs: assert property (@(posedge clk) disable iff (rst)
    $past(rom_off_s) |-> !rom_cs);

  a_r3_latch_sticky: assert property (@(posedge clk) disable iff (rst)
    off_latch |=> off_latch);

  a_r3_latch_sets: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_port == 8'h40 && auto_off_s) |=> off_latch);

  a_r4_latch_stays_clear: assert property (@(posedge clk) disable iff (rst)
    (!off_latch && !(io_wr && io_port == 8'h40 && auto_off_s)) |=> !off_latch);

  a_r3_latch_blocks_cs: assert property (@(posedge clk) disable iff (rst)
    $past(off_latch) |-> !rom_cs);

  a_r7_lock_blocks_fmt: assert property (@(posedge clk) disable iff (rst)
    fmt_permit |-> ($past(fmt_req) && !$past(fmt_lock_s)));

  a_r8_data_zero_idle: assert property (@(posedge clk) disable iff (rst)
    !rom_cs |-> (rom_data == '0));
endmodule

bind boot_rom_window boot_rom_window_chk #(
  .AW(boot_rom_pkg::ADDR_W), .PW(boot_rom_pkg::PORT_W), .DW(boot_rom_pkg::DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rom_off_s  (rom_off_s),
  .auto_off_s (auto_off_s),
  .fmt_lock_s (fmt_lock_s),
  .off_latch  (off_latch),
  .mem_rd     (mem_rd),
  .addr       (addr),
  .io_wr      (io_wr),
  .io_port    (io_port),
  .fmt_req    (fmt_req),
  .rom_cs     (rom_cs),
  .rom_data   (rom_data),
  .fmt_permit (fmt_permit)
);

// File: tb/boot_rom_window_bench.sv
module boot_rom_window_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_rom_off = 1'b0, sw_auto_off = 1'b0;
  logic        sw_boot_direct = 1'b0, sw_fmt_lock = 1'b0;
  logic        mem_rd = 1'b0;
  logic [15:0] addr = '0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_port = '0;
  logic        fmt_req = 1'b0;
  logic        rom_cs;
  logic [7:0]  rom_data;
  logic        boot_direct;
  logic        fmt_permit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  boot_rom_window u_boot_rom_window (
    .clk(clk), .rst(rst),
    .sw_rom_off(sw_rom_off), .sw_auto_off(sw_auto_off),
    .sw_boot_direct(sw_boot_direct), .sw_fmt_lock(sw_fmt_lock),
    .mem_rd(mem_rd), .addr(addr), .io_wr(io_wr), .io_port(io_port),
    .fmt_req(fmt_req), .rom_cs(rom_cs), .rom_data(rom_data),
    .boot_direct(boot_direct), .fmt_permit(fmt_permit)
  );

  function automatic logic [7:0] exp_byte(input logic [15:0] a);
    return a[7:0] ^ {a[9:8], 6'b000000};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one read cycle; result sampled on the following negedge
  task automatic do_read(input logic [15:0] a, input logic rd, output logic cs, output logic [7:0] d);
    mem_rd = rd; addr = a;
    @(negedge clk);
    cs = rom_cs; d = rom_data;
    mem_rd = 1'b0; addr = '0;
  endtask

  task automatic io_write(input logic [7:0] p);
    io_wr = 1'b1; io_port = p;
    @(negedge clk);
    io_wr = 1'b0; io_port = '0;
  endtask

  task automatic expect_read(input string req, input logic [15:0] a, input logic hit);
    logic cs; logic [7:0] d;
    do_read(a, 1'b1, cs, d);
    check(req, cs, hit);
    check(req, d, hit ? exp_byte(a) : 8'h00);
  endtask

  task automatic t_reset();
    ticks(3);
    check("R10", {rom_cs, rom_data, boot_direct, fmt_permit}, '0);
    rst = 1'b0;
    ticks(3);
  endtask

  task automatic t_window();
    logic cs; logic [7:0] d;
    expect_read("R1", 16'hC000, 1'b1);
    expect_read("R1", 16'hC3FF, 1'b1);
    expect_read("R8", 16'hC2A5, 1'b1);
    expect_read("R8", 16'hC17E, 1'b1);
    expect_read("R1", 16'hBFFF, 1'b0);
    expect_read("R1", 16'hC400, 1'b0);
    expect_read("R1", 16'h4000, 1'b0);
    expect_read("R1", 16'hE000, 1'b0);
    do_read(16'hC010, 1'b0, cs, d);
    check("R8", {cs, d}, 9'h000);
  endtask

  task automatic t_off_switch();
    sw_rom_off = 1'b1; ticks(4);
    expect_read("R2", 16'hC000, 1'b0);
    expect_read("R2", 16'hC200, 1'b0);
    sw_rom_off = 1'b0; ticks(4);
    expect_read("R2", 16'hC200, 1'b1);
  endtask

  task automatic t_no_auto();
    sw_auto_off = 1'b0; ticks(4);
    io_write(8'h40);
    expect_read("R4", 16'hC010, 1'b1);
  endtask

  task automatic t_auto_off();
    sw_auto_off = 1'b1; ticks(4);
    io_write(8'h41);
    expect_read("R3", 16'hC011, 1'b1);
    io_write(8'h40);
    expect_read("R3", 16'hC011, 1'b0);
    sw_auto_off = 1'b0; ticks(4);
    expect_read("R3", 16'hC3F0, 1'b0);
  endtask

  task automatic t_reset_clears();
    rst = 1'b1; ticks(2); rst = 1'b0; ticks(3);
    expect_read("R5", 16'hC100, 1'b1);
  endtask

  task automatic t_boot_latency();
    sw_boot_direct = 1'b1;
    ticks(2);
    check("R9", boot_direct, 1'b0);
    ticks(1);
    check("R6", boot_direct, 1'b1);
    sw_boot_direct = 1'b0; ticks(4);
    check("R6", boot_direct, 1'b0);
  endtask

  task automatic t_format();
    fmt_req = 1'b1; ticks(1);
    check("R7", fmt_permit, 1'b1);
    sw_fmt_lock = 1'b1; ticks(4);
    check("R7", fmt_permit, 1'b0);
    sw_fmt_lock = 1'b0; ticks(4);
    check("R7", fmt_permit, 1'b1);
    fmt_req = 1'b0; ticks(1);
    check("R7", fmt_permit, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_window();
    t_off_switch();
    t_no_auto();
    t_auto_off();
    t_reset_clears();
    t_boot_latency();
    t_format();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule